// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It divides a fast input clock by N = P·B + A and emits one single-cycle pulse per N input cycles for the phase detector. The division uses two stages. A dual-modulus prescaler divides by P or by P+1. A main counter B and a swallow counter A both count prescaler cycles. In every output period the first A prescaler cycles run at P+1 and the remaining B−A cycles run at P.

The prescaler is plain synchronous logic in the same clock domain as the counters. The settings for P, A and B come in on static inputs. They are checked and then copied into an active set, which only happens at a period boundary or while the synchronous counter reset is held. An illegal setting raises an error flag and leaves the previous active set in use.

Top module: `psw_fbdiv`

## Requirements
- R1: Outside counter reset, `div_pulse` is high for exactly one clock cycle every N = P·B + A clock cycles, where P, A and B are the active setting.
- R2: `psel_in` selects the prescaler modulus P: code 0 selects P = 8 (8/9), code 1 selects P = 16 (16/17), code 2 selects P = 32 (32/33), and code 3 also selects P = 32.
- R3: `a_in` is a 5-bit value with every value from 0 to 31 accepted. `b_in` is a 13-bit value with every value from 3 to 8191 accepted. The ratio is correct at the boundaries A = 0, A = B, B = 3 and B = 8191.
- R4: Within one output period, the prescaler divides by P+1 for the first A of its cycles and by P for the other B−A cycles. The modulus switches back to P once the swallow count is used up and stays at P until the period ends.
- R5: The inputs are sampled only on the clock edge that ends an output period, or on edges while `cnt_rst` is high. A change in the middle of a period leaves the length of that period unchanged.
- R6: A setting with B < 3 or B < A is illegal. When one is sampled, `cfg_err` goes high and the previous active setting stays in use. The next sampled legal setting clears `cfg_err` and takes effect.
- R7: While `cnt_rst` is high, all counters are held at their start, `div_pulse` stays low, and the inputs are sampled on every edge. After `cnt_rst` falls, the first pulse comes after exactly N cycles.
- R8: After `rst_n` is asserted, `div_pulse` and `cfg_err` are low and the active setting is P = 8, A = 0, B = 3 (N = 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter reset: holds the counters and keeps loading the setting |
| psel_in | input | 2 | Prescaler modulus code (0:8, 1:16, 2:32, 3:32) |
| a_in | input | 5 | Swallow count A |
| b_in | input | 13 | Main count B |
| div_pulse | output | 1 | One-cycle pulse every N input cycles |
| cfg_err | output | 1 | High when the last sampled setting was illegal |

## Verification
The bench builds the block with its default parameters: a 2-bit modulus code, a base modulus of 8 with two doublings, a 5-bit A and a 13-bit B. With these values the code that aliases onto 32, the smallest legal B and the widest B (8191 with P = 8, a single period of 65559 cycles) can all be reached within the run. Random settings use B from 3 to 30, so that many period boundaries fit into the run, and some of them are deliberately illegal. Changes arrive at random points inside a period, so the boundary-only loading is exercised from many phases.

// File: rtl/psw_fbdiv_pkg.sv
package psw_fbdiv_pkg;

   localparam int PSW_PSEL_W    = 2;
   localparam int PSW_A_W       = 5;
   localparam int PSW_B_W       = 13;
   localparam int PSW_BASE_P    = 8;
   localparam int PSW_MAX_SHIFT = 2;
   localparam int PSW_MIN_B     = 3;

   // doubling count applied to the base modulus for a given select code
   function automatic int psw_shift_of(input int code, input int max_shift);
      return (code > max_shift) ? max_shift : code;
   endfunction

endpackage

// File: rtl/psw_cfg_guard.sv
module psw_cfg_guard #(
   parameter int PSEL_W = 2,
   parameter int A_W    = 5,
   parameter int B_W    = 13,
   parameter int MIN_B  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PSEL_W-1:0] psel_in,
   input  logic [A_W-1:0]    a_in,
   input  logic [B_W-1:0]    b_in,
   output logic [PSEL_W-1:0] act_psel,
   output logic [A_W-1:0]    act_a,
   output logic [B_W-1:0]    act_b,
   output logic [A_W-1:0]    nxt_a,
   output logic              cfg_err
);
   localparam logic [B_W-1:0] MIN_B_V = B_W'(MIN_B);

   logic bad;

   assign bad   = (b_in < MIN_B_V) || (b_in < {{(B_W-A_W){1'b0}}, a_in});
   assign nxt_a = bad ? act_a : a_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_psel <= '0;
         act_a    <= '0;
         act_b    <= MIN_B_V;
         cfg_err  <= 1'b0;
      end else if (load) begin
         cfg_err <= bad;
         if (!bad) begin
            act_psel <= psel_in;
            act_a    <= a_in;
            act_b    <= b_in;
         end
      end
   end

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int PC_W = 6
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [PC_W-1:0] p_val,
   input  logic            swallow,
   output logic            tick
);
   logic [PC_W-1:0] cnt;
   logic [PC_W-1:0] last;

   // divides by p_val, or by p_val+1 while the swallow count is still pending
   assign last = p_val - PC_W'(1) + PC_W'(swallow);
   assign tick = !clr && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr || tick)
         cnt <= '0;
      else
         cnt <= cnt + PC_W'(1);
   end

endmodule

// File: rtl/psw_ab_counter.sv
module psw_ab_counter #(
   parameter int A_W = 5,
   parameter int B_W = 13
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           tick,
   input  logic [B_W-1:0] act_b,
   input  logic [A_W-1:0] load_a,
   output logic [A_W-1:0] swl_left,
   output logic           swallow,
   output logic           end_tick
);
   logic [B_W-1:0] b_cnt;
   logic           b_last;

   assign b_last   = (b_cnt == act_b - B_W'(1));
   assign end_tick = tick && b_last;
   assign swallow  = (swl_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_cnt    <= '0;
         swl_left <= '0;
      end else if (clr) begin
         b_cnt    <= '0;
         swl_left <= load_a;
      end else if (tick) begin
         if (b_last) begin
            b_cnt    <= '0;
            swl_left <= load_a;
         end else begin
            b_cnt <= b_cnt + B_W'(1);
            if (swallow)
               swl_left <= swl_left - A_W'(1);
         end
      end
   end

endmodule

// File: rtl/psw_fbdiv.sv
module psw_fbdiv
   import psw_fbdiv_pkg::*;
#(
   parameter int PSEL_W    = PSW_PSEL_W,
   parameter int A_W       = PSW_A_W,
   parameter int B_W       = PSW_B_W,
   parameter int BASE_P    = PSW_BASE_P,
   parameter int MAX_SHIFT = PSW_MAX_SHIFT,
   parameter int MIN_B     = PSW_MIN_B
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_rst,
   input  logic [PSEL_W-1:0] psel_in,
   input  logic [A_W-1:0]    a_in,
   input  logic [B_W-1:0]    b_in,
   output logic              div_pulse,
   output logic              cfg_err
);
   localparam int P_MAX   = BASE_P << MAX_SHIFT;
   localparam int PC_W    = $clog2(P_MAX + 2);
   localparam int N_CODES = 1 << PSEL_W;

   initial begin
      assert (A_W < B_W) else $error("swallow width must be below main width");
      assert (BASE_P >= 2) else $error("base modulus too small");
      assert (MIN_B >= 2) else $error("minimum main count too small");
      assert (PSEL_W >= 1) else $error("select width must be positive");
   end

   logic [PC_W-1:0]   p_lut [N_CODES];
   logic [PSEL_W-1:0] act_psel;
   logic [A_W-1:0]    act_a;
   logic [B_W-1:0]    act_b;
   logic [A_W-1:0]    nxt_a;
   logic [A_W-1:0]    swl_left;
   logic              swallow;
   logic              tick;
   logic              end_tick;
   logic              load;

   for (genvar i = 0; i < N_CODES; i++) begin : g_plut
      localparam int SH = psw_shift_of(i, MAX_SHIFT);
      assign p_lut[i] = PC_W'(BASE_P << SH);
   end

   assign load = cnt_rst || end_tick;

   psw_cfg_guard #(
      .PSEL_W (PSEL_W),
      .A_W    (A_W),
      .B_W    (B_W),
      .MIN_B  (MIN_B)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .psel_in  (psel_in),
      .a_in     (a_in),
      .b_in     (b_in),
      .act_psel (act_psel),
      .act_a    (act_a),
      .act_b    (act_b),
      .nxt_a    (nxt_a),
      .cfg_err  (cfg_err)
   );

   psw_prescaler #(
      .PC_W (PC_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cnt_rst),
      .p_val   (p_lut[act_psel]),
      .swallow (swallow),
      .tick    (tick)
   );

   psw_ab_counter #(
      .A_W (A_W),
      .B_W (B_W)
   ) u_ab (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_rst),
      .tick     (tick),
      .act_b    (act_b),
      .load_a   (nxt_a),
      .swl_left (swl_left),
      .swallow  (swallow),
      .end_tick (end_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_pulse <= 1'b0;
      else
         div_pulse <= end_tick;
   end

endmodule

// File: rtl/psw_fbdiv_chk.sv
module psw_fbdiv_chk #(
   parameter int PSEL_W = 2,
   parameter int A_W    = 5,
   parameter int B_W    = 13,
   parameter int MIN_B  = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_rst,
   input logic [A_W-1:0]    a_in,
   input logic [B_W-1:0]    b_in,
   input logic              div_pulse,
   input logic              cfg_err,
   input logic              load,
   input logic [PSEL_W-1:0] act_psel,
   input logic [A_W-1:0]    act_a,
   input logic [B_W-1:0]    act_b,
   input logic [A_W-1:0]    swl_left
);
   logic in_bad;
   assign in_bad = (b_in < B_W'(MIN_B)) || (b_in < {{(B_W-A_W){1'b0}}, a_in});

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R1

   AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cnt_rst) |=> div_pulse); // R1

   AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((swl_left == '0) && !load) |=> (swl_left == '0)); // R4

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({act_psel, act_a, act_b})); // R5

   AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && in_bad) |=> (cfg_err && $stable({act_psel, act_a, act_b}))); // R6

   AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (act_b >= B_W'(MIN_B)) && (act_b >= {{(B_W-A_W){1'b0}}, act_a})); // R6

   AST_RST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |=> !div_pulse); // R7

endmodule

bind psw_fbdiv psw_fbdiv_chk #(
   .PSEL_W (PSEL_W),
   .A_W    (A_W),
   .B_W    (B_W),
   .MIN_B  (MIN_B)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_rst   (cnt_rst),
   .a_in      (a_in),
   .b_in      (b_in),
   .div_pulse (div_pulse),
   .cfg_err   (cfg_err),
   .load      (load),
   .act_psel  (act_psel),
   .act_a     (act_a),
   .act_b     (act_b),
   .swl_left  (swl_left)
);

// File: tb/psw_fbdiv_test.sv
module psw_fbdiv_test;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 70000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_rst = 1'b0;
   logic [1:0]  psel_in = 2'd1;
   logic [4:0]  a_in = 5'd2;
   logic [12:0] b_in = 13'd5;
   logic        div_pulse;
   logic        cfg_err;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   int    exp_n = 24;
   bit    exp_err = 1'b0;
   bit    saw_pulse;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   psw_fbdiv uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_rst   (cnt_rst),
      .psel_in   (psel_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .div_pulse (div_pulse),
      .cfg_err   (cfg_err)
   );

   function automatic int exp_p(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int ratio(input logic [1:0] code, input int a, input int b);
      return exp_p(code) * b + a;
   endfunction

   function automatic bit legal(input int a, input int b);
      return (b >= 3) && (b >= a);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // model of a sampling edge: period end or counter reset
   task automatic model_load();
      if (legal(int'(a_in), int'(b_in))) begin
         exp_n   = ratio(psel_in, int'(a_in), int'(b_in));
         exp_err = 1'b0;
      end else begin
         exp_err = 1'b1;
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      saw_pulse = div_pulse;
      if (div_pulse) begin
         check(cur_req, cyc, exp_n);
         cyc = 0;
         model_load();
         check("R6 flag", int'(cfg_err), int'(exp_err));
      end
      if (cyc > WD_LIMIT) begin
         failures++;
         $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, exp_n);
         finish_run();
      end
   endtask

   task automatic wait_pulses(input int k);
      int got = 0;
      while (got < k) begin
         step();
         if (saw_pulse) got++;
      end
   endtask

   task automatic set_cfg(input logic [1:0] p, input int a, input int b);
      psel_in = p;
      a_in    = 5'(a);
      b_in    = 13'(b);
   endtask

   task automatic hold_cnt_rst(input int cycles);
      cnt_rst = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check("R7 no pulse in hold", int'(div_pulse), 0);
      end
      model_load();
      check("R7 flag after hold", int'(cfg_err), int'(exp_err));
      cnt_rst = 1'b0;
      cyc = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #(CLK_PERIOD * 2 + 1);
      check("R8 pulse in reset", int'(div_pulse), 0);
      check("R8 flag in reset", int'(cfg_err), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;

      // R8 default ratio 24, then inputs code 1 A=2 B=5 -> 82 (R5)
      cur_req = "R8 default N";
      wait_pulses(1);
      cur_req = "R5 first load";
      wait_pulses(2);

      // R2 code 3 -> 32, R3 min B=3 with A=0
      set_cfg(2'd3, 0, 3);
      cur_req = "R2 R3 code3 Bmin";
      wait_pulses(3);

      // R4 A=B: all prescaler cycles at P+1
      set_cfg(2'd2, 7, 7);
      cur_req = "R4 A equals B";
      wait_pulses(2);

      // R6 illegal B<3 then B<A; previous ratio kept
      set_cfg(2'd0, 0, 2);
      cur_req = "R6 illegal Bsmall";
      wait_pulses(2);
      set_cfg(2'd1, 9, 8);
      cur_req = "R6 illegal B below A";
      wait_pulses(2);
      set_cfg(2'd0, 31, 31);
      cur_req = "R6 recover R3 Amax";
      wait_pulses(2);

      // R5 change mid period: running period keeps old length
      repeat (50) step();
      set_cfg(2'd1, 1, 9);
      cur_req = "R5 mid change";
      wait_pulses(2);

      // R7 counter reset mid period with new setting
      repeat (37) step();
      set_cfg(2'd1, 3, 4);
      hold_cnt_rst(3);
      cur_req = "R7 after release";
      wait_pulses(2);
      repeat (11) step();
      set_cfg(2'd2, 4, 1);
      hold_cnt_rst(2);
      cur_req = "R7 R6 illegal in hold";
      wait_pulses(2);

      // random settings, some illegal, applied at random phases
      for (int t = 0; t < 25; t++) begin
         int b = 3 + int'($urandom_range(27));
         int a = int'($urandom_range((b > 31) ? 31 : b));
         if ($urandom_range(5) == 0) a = b + 1 + int'($urandom_range(2));
         repeat (int'($urandom_range(20))) step();
         set_cfg(2'($urandom_range(3)), a, b);
         cur_req = "R1 random";
         wait_pulses(2);
      end

      // R3 widest B with P=8 and A=31 -> 65559
      set_cfg(2'd0, 31, 8191);
      cur_req = "R3 Bmax";
      wait_pulses(2);
      set_cfg(2'd0, 0, 3);
      cur_req = "R1 final";
      wait_pulses(2);

      finish_run();
   end

endmodule